// File: doc/BRIEF.md
# Macroblock Parameter Double Buffer with Prioritized Readers

This block stages the parameter structure of one macroblock (residual coefficients, motion vectors, prediction and loop-filter settings) in on-chip storage for five downstream decoding engines. Storage is a two-bank dual-port RAM. One bank, the read bank, serves the engines. The other, the fill bank, is loaded from external memory with the structure of the next macroblock. Loading the next structure therefore overlaps with consumption of the current one.

A fill controller runs the fetch handshake with the external memory controller. It writes each returned word into the fill bank and decides when the two banks swap roles. Its states are FC_REQ, FC_LOAD and FC_HOLD:
- FC_REQ raises the fetch request. It moves to FC_LOAD when the controller grants the request.
- FC_LOAD writes the incoming beats in order. It moves to FC_HOLD on the last beat.
- FC_HOLD waits for the swap condition. When the condition is met it moves back to FC_REQ, and in the same edge it flips the bank roles and marks the structure as valid.

A fixed-priority arbiter picks which engine's read request reaches the RAM read port. Its states are ARB_IDLE and ARB_HOLD:
- ARB_IDLE issues a grant when a structure is valid and any engine requests. The grant goes to ARB_HOLD.
- ARB_HOLD keeps the owner while its request stays high. When the owner releases, the grant hands over directly to the highest remaining requester. If no engine is requesting, the arbiter returns to ARB_IDLE.

Top module: `mbs_pingpong_buf`

## Requirements
- R1: In the first cycle after reset, `str_valid`, `rd_valid` and every `cons_gnt` bit are 0, and `fetch_req` is 1.
- R2: `fetch_req` stays high until `fetch_gnt` is sampled high. In the cycle after that grant, `fetch_req` is 0.
- R3: After a fetch grant, the next WORDS cycles with `wr_valid` high store `wr_data` at word addresses 0, 1, 2 and so on of the fill bank. A `wr_valid` beat that arrives while no fill is in progress is ignored and changes no stored word.
- R4: A complete fill, counted from the fetch grant to the last beat, takes no more than FILL_BUDGET (default 94) cycles.
- R5: After reset, the first completed fill makes that bank the read bank without any done indication. `str_valid` rises two cycles after the last beat and stays high afterwards.
- R6: Once a fill is complete and the banks have not yet swapped, `fetch_req` stays low. Further fetches stall.
- R7: Once a structure is valid, the banks swap only when all five engines have pulsed `cons_done` since the previous swap and no grant is active. The done record is cleared at each swap. Until the swap, reads return the older structure.
- R8: No `cons_gnt` bit is ever high while `str_valid` is low.
- R9: Consumer bit positions are 0 inverse transform, 1 intra prediction, 2 inter chroma, 3 inter luma and 4 deblocking filter. From an idle arbiter, the grant visible one cycle after a request pattern is the highest set bit. At most one grant bit is high at any time.
- R10: A grant stays with its owner while the owner's request stays high, even when a higher-priority engine starts requesting. One cycle after the owner drops its request, the grant passes to the highest remaining requester.
- R11: A `cons_addr` slice presented by the granted engine returns the stored word of the read bank on `rd_data`, with `rd_valid` high, one cycle later.
- R12: In the cycle after a swap, `fetch_req` is high again to fetch the next structure into the freed bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | output | 1 | Request to the memory controller for the next structure |
| fetch_gnt | input | 1 | Memory controller accepts the fetch request |
| wr_valid | input | 1 | Fetched data beat valid |
| wr_data | input | DW | Fetched data beat |
| cons_req | input | 5 | Read request per engine (bit map in R9) |
| cons_addr | input | 5*AW | Word address per engine, slice i belongs to engine i |
| cons_done | input | 5 | One-cycle pulse: engine has finished with the read bank |
| cons_gnt | output | 5 | One-hot read grant |
| rd_data | output | DW | Read data |
| rd_valid | output | 1 | `rd_data` carries a word read for the granted engine |
| str_valid | output | 1 | The read bank holds a complete structure |

## Verification
Some properties are checked on every cycle:
- the grant is one-hot or empty, and never appears without a valid structure;
- a held grant does not move while its owner keeps requesting;
- the fetch request stays up until it is granted and is never raised during a write;
- read data is valid only after a grant;
- every fill ends within the cycle budget.

Other behaviour can be shown only by bench scenarios:
- which bank a read actually hits before and after a swap;
- that a partial set of done pulses does not swap the banks;
- that stray write beats leave the stored structure unchanged;
- the chosen winner across random request patterns.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    // number of reading engines, bit map fixed by priority
    localparam int NCONS = 5;

    typedef enum logic [1:0] {
        FC_REQ  = 2'd0,
        FC_LOAD = 2'd1,
        FC_HOLD = 2'd2
    } fill_st_e;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_HOLD = 1'b1
    } arb_st_e;

endpackage

// File: rtl/mbs_bank_mem.sv
module mbs_bank_mem #(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wbank,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic          rbank,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 2 * (1 << AW);

    logic [DW-1:0] mem [DEPTH];

    // write port, fill bank only
    always_ff @(posedge clk) begin
        if (we) begin
            mem[{wbank, waddr}] <= wdata;
        end
    end

    // registered read port, read bank only
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[{rbank, raddr}];
        end
    end

endmodule

// File: rtl/mbs_fill_ctrl.sv
module mbs_fill_ctrl
    import mbs_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int AW     = 6,
    parameter int BUDGET = 94,
    parameter int NC     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          fetch_req,
    input  logic          fetch_gnt,
    input  logic          wr_valid,
    input  logic [NC-1:0] cons_done,
    input  logic          arb_busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic          rd_bank,
    output logic          str_valid
);
    localparam int CW = $clog2(BUDGET + 2);
    localparam logic [AW-1:0] LAST_W = AW'(WORDS - 1);
    localparam logic [CW-1:0] CMAX   = CW'(BUDGET + 1);

    fill_st_e        state, nstate;
    logic [AW-1:0]   wcnt;
    logic [NC-1:0]   done_mask;
    logic [NC-1:0]   done_seen;
    logic [CW-1:0]   load_cyc;
    logic            last_beat;
    logic            swap;

    assign done_seen = done_mask | cons_done;
    assign last_beat = (state == FC_LOAD) && wr_valid && (wcnt == LAST_W);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FC_REQ;
        end else begin
            state <= nstate;
        end
    end

    // next state and outputs
    always_comb begin
        nstate    = state;
        fetch_req = 1'b0;
        mem_we    = 1'b0;
        swap      = 1'b0;
        unique case (state)
            FC_REQ: begin
                fetch_req = 1'b1;
                if (fetch_gnt) nstate = FC_LOAD;
            end
            FC_LOAD: begin
                mem_we = wr_valid;
                if (last_beat) nstate = FC_HOLD;
            end
            FC_HOLD: begin
                if (!arb_busy && (!str_valid || (&done_seen))) begin
                    swap   = 1'b1;
                    nstate = FC_REQ;
                end
            end
            default: nstate = FC_REQ;
        endcase
    end

    assign mem_waddr = wcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt      <= '0;
            done_mask <= '0;
            rd_bank   <= 1'b0;
            str_valid <= 1'b0;
            load_cyc  <= '0;
        end else begin
            if (state == FC_REQ) begin
                wcnt     <= '0;
                load_cyc <= '0;
            end else if (state == FC_LOAD) begin
                if (wr_valid) wcnt <= wcnt + 1'b1;
                if (load_cyc != CMAX) load_cyc <= load_cyc + 1'b1;
            end
            if (swap || !str_valid) begin
                done_mask <= '0;
            end else begin
                done_mask <= done_seen;
            end
            if (swap) begin
                rd_bank   <= ~rd_bank;
                str_valid <= 1'b1;
            end
        end
    end

    // R2: a raised fetch request is held until granted
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_gnt) |=> fetch_req);

    // R4: the last beat lands inside the cycle budget
    a_r4_fill_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FC_LOAD) |-> (load_cyc < CW'(BUDGET)));

    // R6: no new fetch is requested while beats are being stored
    a_r6_no_req_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !fetch_req);

    // R12: the first bank flip restarts fetching at once
    a_r12_refetch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(str_valid) |-> fetch_req);

endmodule

// File: rtl/mbs_prio_arb.sv
module mbs_prio_arb
    import mbs_pkg::*;
#(
    parameter int NC = 5,
    parameter int AW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [NC-1:0]    req,
    input  logic [NC*AW-1:0] addr,
    output logic [NC-1:0]    gnt,
    output logic             busy,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr
);
    localparam int IW = (NC > 1) ? $clog2(NC) : 1;

    arb_st_e       state, nstate;
    logic [IW-1:0] owner, nowner;

    // highest index wins
    function automatic logic [IW-1:0] pick(input logic [NC-1:0] r);
        logic [IW-1:0] idx;
        idx = '0;
        for (int i = 0; i < NC; i++) begin
            if (r[i]) idx = IW'(i);
        end
        return idx;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ARB_IDLE;
            owner <= '0;
        end else begin
            state <= nstate;
            owner <= nowner;
        end
    end

    // next state
    always_comb begin
        nstate = state;
        nowner = owner;
        unique case (state)
            ARB_IDLE: begin
                if (en && (|req)) begin
                    nstate = ARB_HOLD;
                    nowner = pick(req);
                end
            end
            ARB_HOLD: begin
                if (!req[owner]) begin
                    if (en && (|req)) begin
                        nowner = pick(req);
                    end else begin
                        nstate = ARB_IDLE;
                    end
                end
            end
            default: nstate = ARB_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = (state == ARB_HOLD);
        gnt     = busy ? (NC'(1) << owner) : '0;
        rd_en   = busy && req[owner];
        rd_addr = addr[owner*AW +: AW];
    end

    // R9: grant is one-hot or empty
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R10: an owner that keeps requesting keeps its grant
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (|(gnt & req)) |=> (gnt == $past(gnt)));

endmodule

// File: rtl/mbs_pingpong_buf.sv
module mbs_pingpong_buf
    import mbs_pkg::*;
#(
    parameter int DW          = 32,
    parameter int WORDS       = 64,
    parameter int FILL_BUDGET = 94,
    localparam int AW         = $clog2(WORDS),
    localparam int NC         = NCONS
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             fetch_req,
    input  logic             fetch_gnt,
    input  logic             wr_valid,
    input  logic [DW-1:0]    wr_data,
    input  logic [NC-1:0]    cons_req,
    input  logic [NC*AW-1:0] cons_addr,
    input  logic [NC-1:0]    cons_done,
    output logic [NC-1:0]    cons_gnt,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             str_valid
);
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic          rd_bank;
    logic          arb_busy;
    logic          rd_en;
    logic [AW-1:0] rd_addr;

    mbs_fill_ctrl #(
        .WORDS (WORDS),
        .AW    (AW),
        .BUDGET(FILL_BUDGET),
        .NC    (NC)
    ) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetch_req(fetch_req),
        .fetch_gnt(fetch_gnt),
        .wr_valid (wr_valid),
        .cons_done(cons_done),
        .arb_busy (arb_busy),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr),
        .rd_bank  (rd_bank),
        .str_valid(str_valid)
    );

    mbs_prio_arb #(
        .NC(NC),
        .AW(AW)
    ) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (str_valid),
        .req    (cons_req),
        .addr   (cons_addr),
        .gnt    (cons_gnt),
        .busy   (arb_busy),
        .rd_en  (rd_en),
        .rd_addr(rd_addr)
    );

    mbs_bank_mem #(
        .DW(DW),
        .AW(AW)
    ) u_mem (
        .clk  (clk),
        .we   (mem_we),
        .wbank(~rd_bank),
        .waddr(mem_waddr),
        .wdata(wr_data),
        .re   (rd_en),
        .rbank(rd_bank),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
        end
    end

    // R8: grants only once a structure is valid
    a_r8_gnt_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (|cons_gnt) |-> str_valid);

    // R11: read data follows a grant by one cycle
    a_r11_rd_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(|cons_gnt));

endmodule

// File: tb/mbs_pingpong_buf_bench.sv
module mbs_pingpong_buf_bench;
    localparam int DW    = 32;
    localparam int WORDS = 64;
    localparam int AW    = $clog2(WORDS);
    localparam int NC    = 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             fetch_req;
    logic             fetch_gnt;
    logic             wr_valid;
    logic [DW-1:0]    wr_data;
    logic [NC-1:0]    cons_req;
    logic [NC*AW-1:0] cons_addr;
    logic [NC-1:0]    cons_done;
    logic [NC-1:0]    cons_gnt;
    logic [DW-1:0]    rd_data;
    logic             rd_valid;
    logic             str_valid;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    int unsigned seed_dummy;

    always #10 clk = ~clk;

    mbs_pingpong_buf #(.DW(DW), .WORDS(WORDS), .FILL_BUDGET(94)) u_mbs_pingpong_buf (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_gnt(fetch_gnt),
        .wr_valid(wr_valid), .wr_data(wr_data), .cons_req(cons_req),
        .cons_addr(cons_addr), .cons_done(cons_done), .cons_gnt(cons_gnt),
        .rd_data(rd_data), .rd_valid(rd_valid), .str_valid(str_valid)
    );

    function automatic logic [DW-1:0] word_of(input int mb, input int w);
        return {8'(mb), 8'hA5, 8'(w), 8'(w * 3 + mb)};
    endfunction

    function automatic logic [NC-1:0] winner(input logic [NC-1:0] m);
        logic [NC-1:0] r;
        r = '0;
        for (int i = 0; i < NC; i++) begin
            if (m[i]) r = NC'(1) << i;
        end
        return r;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_fill(input int mb, input bit stray);
        int tries;
        int gaps;
        tries = 0;
        while (!fetch_req && tries < 300) begin
            tick();
            tries++;
        end
        check(fetch_req == 1'b1, "R12 fetch_req awaited", 64'(fetch_req), 64'd1);
        fetch_gnt = 1'b1;
        tick();
        fetch_gnt = 1'b0;
        check(fetch_req == 1'b0, "R2 req drops after grant", 64'(fetch_req), 64'd0);
        gaps = 0;
        for (int w = 0; w < WORDS; w++) begin
            if (gaps < 20 && ($urandom % 6) == 0) begin
                wr_valid = 1'b0;
                gaps++;
                tick();
            end
            wr_valid = 1'b1;
            wr_data  = word_of(mb, w);
            tick();
        end
        wr_valid = 1'b0;
        if (stray) begin
            // R3: beats outside a fill must be dropped
            for (int k = 0; k < 5; k++) begin
                wr_valid = 1'b1;
                wr_data  = 32'hDEAD_0000 | 32'(k);
                tick();
            end
            wr_valid = 1'b0;
        end
    endtask

    task automatic read_one(input int c, input int a, input logic [DW-1:0] exp, input string tag);
        int tries;
        cons_addr[c*AW +: AW] = AW'(a);
        cons_req[c] = 1'b1;
        tries = 0;
        tick();
        while (!cons_gnt[c] && tries < 40) begin
            tick();
            tries++;
        end
        tick();
        check(rd_valid == 1'b1 && rd_data == exp, tag, 64'(rd_data), 64'(exp));
        cons_req[c] = 1'b0;
        tick();
    endtask

    task automatic pulse_done(input logic [NC-1:0] m);
        cons_done = m;
        tick();
        cons_done = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] m;
        seed_dummy = $urandom(32'd1234);
        rst_n = 1'b0; fetch_gnt = 1'b0; wr_valid = 1'b0; wr_data = '0;
        cons_req = '0; cons_addr = '0; cons_done = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        check(str_valid == 1'b0, "R1 str_valid", 64'(str_valid), 64'd0);
        check(cons_gnt == '0, "R1 gnt", 64'(cons_gnt), 64'd0);
        check(rd_valid == 1'b0, "R1 rd_valid", 64'(rd_valid), 64'd0);
        check(fetch_req == 1'b1, "R1 fetch_req", 64'(fetch_req), 64'd1);

        // R8: no grant before first structure
        cons_req = '1;
        repeat (3) tick();
        check(cons_gnt == '0, "R8 no grant while empty", 64'(cons_gnt), 64'd0);
        cons_req = '0;
        tick();

        // R5: first fill swaps in without done pulses
        do_fill(0, 1'b0);
        tick();
        check(str_valid == 1'b1, "R5 first structure valid", 64'(str_valid), 64'd1);
        check(fetch_req == 1'b1, "R12 refetch after first swap", 64'(fetch_req), 64'd1);

        // R11 / R3: random reads of structure 0
        for (int k = 0; k < 16; k++) begin
            int c, a;
            c = int'($urandom % NC);
            a = int'($urandom % WORDS);
            read_one(c, a, word_of(0, a), "R11 read structure 0");
        end

        // R6 / R3: fill 1 then stray beats; stall
        do_fill(1, 1'b1);
        repeat (4) tick();
        check(fetch_req == 1'b0, "R6 fetch stalls while full", 64'(fetch_req), 64'd0);
        read_one(2, 7, word_of(0, 7), "R7 old structure before done");

        // R7: four of five done, no swap
        pulse_done(5'b01111);
        repeat (3) tick();
        check(fetch_req == 1'b0, "R7 partial done keeps banks", 64'(fetch_req), 64'd0);
        read_one(4, 63, word_of(0, 63), "R7 still structure 0");
        pulse_done(5'b10000);
        tick();
        check(fetch_req == 1'b1, "R12 refetch after swap", 64'(fetch_req), 64'd1);
        read_one(0, 0, word_of(1, 0), "R3 word 0 of structure 1");
        read_one(3, 63, word_of(1, 63), "R3 last word not hit by stray beats");

        // R9: priority directed and random
        cons_req = 5'b11111; tick();
        check(cons_gnt == 5'b10000, "R9 all request", 64'(cons_gnt), 64'h10);
        cons_req = '0; repeat (2) tick();
        cons_req = 5'b00011; tick();
        check(cons_gnt == 5'b00010, "R9 low pair", 64'(cons_gnt), 64'h2);
        cons_req = '0; repeat (2) tick();
        for (int k = 0; k < 16; k++) begin
            m = NC'($urandom % 31 + 1);
            cons_req = m; tick();
            check(cons_gnt == winner(m), "R9 random pattern", 64'(cons_gnt), 64'(winner(m)));
            cons_req = '0; repeat (2) tick();
        end

        // R10: hold and hand-over
        cons_req = 5'b00001; tick();
        check(cons_gnt == 5'b00001, "R10 low owner granted", 64'(cons_gnt), 64'h1);
        cons_req = 5'b10001; tick();
        check(cons_gnt == 5'b00001, "R10 grant held", 64'(cons_gnt), 64'h1);
        cons_req = 5'b10000; tick();
        check(cons_gnt == 5'b10000, "R10 hand-over", 64'(cons_gnt), 64'h10);
        cons_req = '0; repeat (2) tick();

        // overlap: fill structure 2 while reading structure 1
        fork
            do_fill(2, 1'b0);
            begin
                for (int k = 0; k < 10; k++) begin
                    int a;
                    a = int'($urandom % WORDS);
                    read_one(k % NC, a, word_of(1, a), "R7 read during fill");
                end
            end
        join
        repeat (3) tick();
        // R7: done record was cleared by the previous swap
        read_one(1, 5, word_of(1, 5), "R7 done record cleared");
        pulse_done(5'b11111);
        tick();
        read_one(4, 9, word_of(2, 9), "R7 structure 2 after swap");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule